// File: doc/BRIEF.md
# I2C Serial Clock Timing Generator

This block makes the serial clock waveform for an I2C master from a fast functional clock. The clock is divided in two stages. A programmable prescaler first turns the functional clock into an internal sampling tick. The low and the high halves of each SCL period are then counted separately in those ticks. Software works out the divider values and programs a prescaler value and two 16-bit phase registers. Each phase register holds two 8-bit count fields. Standard and fast mode use only the lower field. The two-phase high-speed mode uses the lower field until the master code has gone out, and the upper field after that.

Each programmed count is stored without a fixed trim offset. The hardware adds a per-phase trim constant back when it counts. The block drives SCL as an open-drain line: it either pulls the line low or releases it. It counts the high phase only once the line has actually been seen high, so a slave that holds SCL low stretches the period. The configuration is captured when the enable rises, and changes made while enabled have no effect. A configuration that is not legal never starts the clock. Dropping the enable releases the line and clears both counters.

Top module: `sclgen_timer`

## Requirements
- R1: While a phase is being counted, `sampleTick` pulses for one cycle every PSC+1 functional clock cycles. The first pulse comes PSC cycles after the phase begins, with the phase's first cycle counted as cycle 0.
- R2: Each low phase pulls SCL low (`sclPullLow`=1) for exactly (F_low+LOW_TRIM)*(PSC+1) cycles. F_low is the selected low field.
- R3: After a low phase, SCL is released. The block waits one cycle with `clkPhaseHigh`=0 to see the line high. It then counts (F_high+HIGH_TRIM)*(PSC+1) cycles with `clkPhaseHigh`=1. If the line is not held, each released interval is therefore 1+(F_high+HIGH_TRIM)*(PSC+1) cycles long.
- R4: If a device holds SCL low for S>=1 cycles after the release, the high count does not start and `clkPhaseHigh` stays 0. The released interval becomes S+(F_high+HIGH_TRIM)*(PSC+1) cycles.
- R5: With `modeHs`=0, only bits [7:0] of `lowIn` and `highIn` are used. Bits [15:8] and `hsSwitch` have no effect, and `hsPhase` stays 0.
- R6: A configuration is illegal if PSC is 0, if a used 8-bit field is 0, or, with `modeHs`=1, if bits [15:8] of either register are 0. When the enable rises on an illegal configuration, SCL is never pulled low.
- R7: The prescaler, the fields and the mode are captured only on a rising edge of `enable`. Input changes while enabled, including a change from an illegal to a legal configuration, do not alter the running timing.
- R8: With `modeHs`=1, phases use bits [7:0] until `hsSwitch` pulses. `hsPhase` is 1 from the next cycle on. Every phase that begins after that uses bits [15:8], and the phase in progress keeps its count.
- R9: Under reset, and one cycle after `enable` falls, `sclPullLow`, `clkPhaseHigh`, `sampleTick` and `hsPhase` are all 0. On re-enabling, the first low phase is a full-length one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable; a rising edge captures the configuration |
| modeHs | input | 1 | 1 selects the two-phase high-speed timing |
| pscIn | input | PSC_W | Prescaler value; tick period is pscIn+1 |
| lowIn | input | 2*FIELD_W | Low-phase counts: [7:0] first set, [15:8] second set |
| highIn | input | 2*FIELD_W | High-phase counts: [7:0] first set, [15:8] second set |
| hsSwitch | input | 1 | One-cycle pulse after the master code byte |
| sclIn | input | 1 | Observed SCL line level |
| sampleTick | output | 1 | Internal sampling clock tick |
| sclPullLow | output | 1 | 1 pulls SCL low, 0 releases it |
| clkPhaseHigh | output | 1 | 1 while the high phase is being counted |
| hsPhase | output | 1 | 1 once the second timing set is selected |

## Verification
The bench builds the block with 8-bit prescaler and fields and overrides the trims to LOW_TRIM=2 and HIGH_TRIM=1. With these values, the smallest legal field gives three- and two-tick phases, and a prescaler of 1 halves the functional clock. Every phase boundary, including the first-versus-second timing set in high-speed mode and a stretched release, therefore falls within a few dozen cycles of measurement. One case still uses a full 255 field, so the widened target counter is tested at its top value.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_LOW,
    ST_WAIT,
    ST_HIGH
  } sclState_t;

  typedef struct packed {
    logic loadCfg;
    logic clrCounts;
    logic countEn;
    logic loadLowTgt;
    logic loadHighTgt;
    logic armed;
  } sclStrobe_t;

endpackage

// File: rtl/sclgen_datapath.sv
module sclgen_datapath
  import sclgen_pkg::*;
#(
  parameter int PSC_W     = 8,
  parameter int FIELD_W   = 8,
  parameter int LOW_TRIM  = 7,
  parameter int HIGH_TRIM = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   enable,
  input  sclStrobe_t             strobe,
  input  logic [PSC_W-1:0]       pscIn,
  input  logic [2*FIELD_W-1:0]   lowIn,
  input  logic [2*FIELD_W-1:0]   highIn,
  input  logic                   modeHs,
  input  logic                   hsSwitch,
  output logic                   sampleTick,
  output logic                   phaseDone,
  output logic                   cfgLegal,
  output logic                   hsActive
);

  localparam int REG_W  = 2 * FIELD_W;
  localparam int TGT_W  = FIELD_W + 1;
  localparam int N_SETS = 2;
  localparam logic [TGT_W-1:0] LOW_ADD  = TGT_W'(LOW_TRIM);
  localparam logic [TGT_W-1:0] HIGH_ADD = TGT_W'(HIGH_TRIM);

  logic [PSC_W-1:0]   pscReg;
  logic [PSC_W-1:0]   psCnt;
  logic [REG_W-1:0]   lowReg;
  logic [REG_W-1:0]   highReg;
  logic               hsModeReg;
  logic [TGT_W-1:0]   phaseTgt;
  logic [TGT_W-1:0]   phCnt;
  logic [N_SETS-1:0]  setOk;
  logic [FIELD_W-1:0] lowField;
  logic [FIELD_W-1:0] highField;
  logic               psMatch;
  logic               phMatch;

  // Legality of each timing set, checked on the raw inputs at start time
  generate
    for (genvar g = 0; g < N_SETS; g++) begin : g_setChk
      assign setOk[g] = (lowIn[g*FIELD_W +: FIELD_W] != '0) &&
                        (highIn[g*FIELD_W +: FIELD_W] != '0);
    end
  endgenerate

  assign cfgLegal = (pscIn != '0) && setOk[0] && (!modeHs || setOk[1]);

  // Configuration capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscReg    <= '0;
      lowReg    <= '0;
      highReg   <= '0;
      hsModeReg <= 1'b0;
    end else if (strobe.loadCfg) begin
      pscReg    <= pscIn;
      lowReg    <= lowIn;
      highReg   <= highIn;
      hsModeReg <= modeHs;
    end
  end

  // Timing set selection
  assign lowField  = hsActive ? lowReg[REG_W-1:FIELD_W]  : lowReg[FIELD_W-1:0];
  assign highField = hsActive ? highReg[REG_W-1:FIELD_W] : highReg[FIELD_W-1:0];

  // Phase target, frozen at phase entry with the trim added back
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseTgt <= '0;
    end else if (strobe.loadLowTgt) begin
      phaseTgt <= {1'b0, lowField} + LOW_ADD;
    end else if (strobe.loadHighTgt) begin
      phaseTgt <= {1'b0, highField} + HIGH_ADD;
    end
  end

  assign psMatch = (psCnt == pscReg);
  assign phMatch = (phCnt == phaseTgt - TGT_W'(1));

  // Prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCnt <= '0;
    end else if (strobe.clrCounts) begin
      psCnt <= '0;
    end else if (strobe.countEn) begin
      psCnt <= psMatch ? '0 : psCnt + PSC_W'(1);
    end
  end

  // Phase tick counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phCnt <= '0;
    end else if (strobe.clrCounts) begin
      phCnt <= '0;
    end else if (strobe.countEn && psMatch) begin
      phCnt <= phMatch ? '0 : phCnt + TGT_W'(1);
    end
  end

  // Second timing set flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsActive <= 1'b0;
    end else if (!enable || strobe.loadCfg) begin
      hsActive <= 1'b0;
    end else if (strobe.armed && hsModeReg && hsSwitch) begin
      hsActive <= 1'b1;
    end
  end

  assign sampleTick = strobe.countEn && psMatch;
  assign phaseDone  = psMatch && phMatch;

endmodule

// File: rtl/sclgen_control.sv
module sclgen_control
  import sclgen_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       sclIn,
  input  logic       cfgLegal,
  input  logic       phaseDone,
  output sclStrobe_t strobe,
  output sclState_t  state
);

  sclState_t nextState;
  logic      enPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      enPrev <= 1'b0;
    end else begin
      state  <= nextState;
      enPrev <= enable;
    end
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    strobe.armed = (state != ST_IDLE);
    if (!enable) begin
      nextState        = ST_IDLE;
      strobe.clrCounts = 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          strobe.clrCounts = 1'b1;
          if (!enPrev && cfgLegal) begin
            strobe.loadCfg = 1'b1;
            nextState      = ST_START;
          end
        end
        ST_START: begin
          strobe.loadLowTgt = 1'b1;
          strobe.clrCounts  = 1'b1;
          nextState         = ST_LOW;
        end
        ST_LOW: begin
          strobe.countEn = 1'b1;
          if (phaseDone) begin
            strobe.clrCounts = 1'b1;
            nextState        = ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (sclIn) begin
            strobe.loadHighTgt = 1'b1;
            strobe.clrCounts   = 1'b1;
            nextState          = ST_HIGH;
          end
        end
        ST_HIGH: begin
          strobe.countEn = 1'b1;
          if (phaseDone) begin
            strobe.loadLowTgt = 1'b1;
            strobe.clrCounts  = 1'b1;
            nextState         = ST_LOW;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sclgen_timer.sv
module sclgen_timer
  import sclgen_pkg::*;
#(
  parameter int PSC_W     = 8,
  parameter int FIELD_W   = 8,
  parameter int LOW_TRIM  = 7,
  parameter int HIGH_TRIM = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic                 modeHs,
  input  logic [PSC_W-1:0]     pscIn,
  input  logic [2*FIELD_W-1:0] lowIn,
  input  logic [2*FIELD_W-1:0] highIn,
  input  logic                 hsSwitch,
  input  logic                 sclIn,
  output logic                 sampleTick,
  output logic                 sclPullLow,
  output logic                 clkPhaseHigh,
  output logic                 hsPhase
);

  sclStrobe_t strobe;
  sclState_t  state;
  logic       phaseDone;
  logic       cfgLegal;

  sclgen_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .sclIn     (sclIn),
    .cfgLegal  (cfgLegal),
    .phaseDone (phaseDone),
    .strobe    (strobe),
    .state     (state)
  );

  sclgen_datapath #(
    .PSC_W     (PSC_W),
    .FIELD_W   (FIELD_W),
    .LOW_TRIM  (LOW_TRIM),
    .HIGH_TRIM (HIGH_TRIM)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .strobe     (strobe),
    .pscIn      (pscIn),
    .lowIn      (lowIn),
    .highIn     (highIn),
    .modeHs     (modeHs),
    .hsSwitch   (hsSwitch),
    .sampleTick (sampleTick),
    .phaseDone  (phaseDone),
    .cfgLegal   (cfgLegal),
    .hsActive   (hsPhase)
  );

  assign sclPullLow   = (state == ST_LOW);
  assign clkPhaseHigh = (state == ST_HIGH);

endmodule

// File: rtl/sclgen_checker.sv
module sclgen_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic sclIn,
  input logic sampleTick,
  input logic sclPullLow,
  input logic clkPhaseHigh,
  input logic hsPhase
);

  // R1: a prescaler of at least 1 never gives back-to-back ticks
  assert_tick_spaced_R1: assert property (@(posedge clk) disable iff (!rstN)
    sampleTick |=> !sampleTick);

  // R3: the high count never runs while the line is pulled low
  assert_high_released_R3: assert property (@(posedge clk) disable iff (!rstN)
    clkPhaseHigh |-> !sclPullLow);

  // R4: a line held low keeps the high count from starting
  assert_stretch_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!sclPullLow && !sclIn && !clkPhaseHigh) |=> !clkPhaseHigh);

  // R8: once selected, the second timing set stays while enabled
  assert_hs_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hsPhase && enable) |=> hsPhase);

  // R9: disabling releases the line and stops the counters
  assert_disable_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sclPullLow && !clkPhaseHigh && !sampleTick && !hsPhase));

endmodule

bind sclgen_timer sclgen_checker u_sclgenChk (.*);

// File: tb/tb_sclgen_timer.sv
module tb_sclgen_timer;

  localparam int PSC_W = 8;
  localparam int FIELD_W = 8;
  localparam int LT = 2;
  localparam int HT = 1;

  typedef struct {
    bit    level;
    int    len;
    string tag;
  } runItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic modeHs = 1'b0;
  logic [PSC_W-1:0] pscIn = '0;
  logic [2*FIELD_W-1:0] lowIn = '0;
  logic [2*FIELD_W-1:0] highIn = '0;
  logic hsSwitch = 1'b0;
  logic extHold = 1'b0;
  logic sclIn;
  logic sampleTick, sclPullLow, clkPhaseHigh, hsPhase;

  int checkCount = 0;
  int failCount = 0;
  int stretchLen = 0;
  runItem_t expQ[$];

  always #4 clk = ~clk;

  assign sclIn = !sclPullLow && !extHold;

  sclgen_timer #(
    .PSC_W(PSC_W), .FIELD_W(FIELD_W), .LOW_TRIM(LT), .HIGH_TRIM(HT)
  ) dut (
    .clk(clk), .rstN(rstN), .enable(enable), .modeHs(modeHs),
    .pscIn(pscIn), .lowIn(lowIn), .highIn(highIn), .hsSwitch(hsSwitch),
    .sclIn(sclIn), .sampleTick(sampleTick), .sclPullLow(sclPullLow),
    .clkPhaseHigh(clkPhaseHigh), .hsPhase(hsPhase)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int lowLen(input int p, input int f);
    return (f + LT) * (p + 1);
  endfunction

  function automatic int relLen(input int p, input int f, input int s);
    return ((s > 1) ? s : 1) + (f + HT) * (p + 1);
  endfunction

  // Monitor: measure runs of the SCL drive level and score them
  bit started = 0;
  bit prevLvl = 0;
  int runLen = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (started && sclPullLow == prevLvl) begin
        runLen++;
      end else begin
        if (started && expQ.size() > 0 && expQ[0].level == prevLvl) begin
          runItem_t it;
          it = expQ.pop_front();
          check(runLen == it.len, it.tag, runLen, it.len);
        end
        prevLvl = sclPullLow;
        runLen = 1;
        started = 1;
      end
    end
  end

  // External device holding SCL low after each release
  initial begin
    forever begin
      @(negedge sclPullLow);
      if (stretchLen > 0) begin
        extHold = 1'b1;
        repeat (stretchLen) @(negedge clk);
        extHold = 1'b0;
      end
    end
  end

  task automatic pushPeriods(input int n, input int lo, input int rel, input string tag);
    for (int i = 0; i < n; i++) begin
      expQ.push_back('{1'b1, lo, tag});
      expQ.push_back('{1'b0, rel, tag});
    end
  endtask

  task automatic waitQueue();
    while (expQ.size() > 0) @(negedge clk);
  endtask

  task automatic setCfg(input int p, input int lo, input int hi, input bit hs);
    pscIn = PSC_W'(p);
    lowIn = 16'(lo);
    highIn = 16'(hi);
    modeHs = hs;
  endtask

  task automatic stopRun();
    @(negedge clk);
    enable = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic runCase(input int p, input int lo, input int hi, input int n,
                         input int s, input string tag);
    setCfg(p, lo, hi, 1'b0);
    stretchLen = s;
    pushPeriods(n, lowLen(p, lo & 8'hff), relLen(p, hi & 8'hff, s), tag);
    @(negedge clk);
    enable = 1'b1;
    waitQueue();
    stopRun();
    stretchLen = 0;
  endtask

  task automatic illegalCase(input int p, input int lo, input int hi, input bit hs,
                             input bit fixLater, input string tag);
    bit sawLow = 0;
    setCfg(p, lo, hi, hs);
    @(negedge clk);
    enable = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sclPullLow) sawLow = 1;
      if (fixLater && i == 20) setCfg(2, 5, 5, 1'b0);
    end
    check(!sawLow, tag, sawLow, 0);
    stopRun();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!sclPullLow && !clkPhaseHigh && !sampleTick && !hsPhase, "R9 reset outputs",
          {sclPullLow, clkPhaseHigh, sampleTick, hsPhase}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R3: standard-like equal halves
    runCase(2, 4, 4, 3, 0, "R2R3 equal halves");
    // R2 R3: fast-like two-thirds low
    runCase(1, 9, 3, 2, 0, "R2R3 unequal halves");
    // R2 R3: smallest legal fields and prescaler
    runCase(1, 1, 1, 2, 0, "R2R3 minimum counts");
    // R2: largest field
    runCase(1, 255, 1, 1, 0, "R2 maximum low field");
    // R4: clock stretching
    runCase(2, 2, 3, 2, 7, "R4 stretched release");

    // R7: writes while enabled are ignored
    setCfg(2, 3, 3, 1'b0);
    pushPeriods(2, lowLen(2, 3), relLen(2, 3, 0), "R7 write while enabled");
    @(negedge clk);
    enable = 1'b1;
    repeat (2) @(negedge clk);
    setCfg(5, 8, 8, 1'b1);
    waitQueue();
    stopRun();

    // R5: upper fields and hsSwitch ignored outside high-speed mode
    setCfg(1, 16'h3302, 16'h4403, 1'b0);
    pushPeriods(2, lowLen(1, 2), relLen(1, 3, 0), "R5 upper bytes ignored");
    @(negedge clk);
    enable = 1'b1;
    while (!sclPullLow) @(negedge clk);
    hsSwitch = 1'b1;
    @(negedge clk);
    hsSwitch = 1'b0;
    @(negedge clk);
    check(hsPhase == 1'b0, "R5 hsPhase stays low", hsPhase, 0);
    waitQueue();
    stopRun();

    // R8: high-speed mode switches timing sets after hsSwitch
    setCfg(1, 16'h0602, 16'h0501, 1'b1);
    expQ.push_back('{1'b1, lowLen(1, 2), "R8 first set low"});
    expQ.push_back('{1'b0, relLen(1, 5, 0), "R8 second set high"});
    expQ.push_back('{1'b1, lowLen(1, 6), "R8 second set low"});
    expQ.push_back('{1'b0, relLen(1, 5, 0), "R8 second set high again"});
    @(negedge clk);
    enable = 1'b1;
    while (!sclPullLow) @(negedge clk);
    check(hsPhase == 1'b0, "R8 hsPhase before switch", hsPhase, 0);
    hsSwitch = 1'b1;
    @(negedge clk);
    hsSwitch = 1'b0;
    check(hsPhase == 1'b1, "R8 hsPhase after switch", hsPhase, 1);
    waitQueue();
    stopRun();
    check(hsPhase == 1'b0, "R9 hsPhase cleared by disable", hsPhase, 0);

    // R6: illegal configurations never start; R7: later fix while enabled ignored
    illegalCase(0, 5, 5, 1'b0, 1'b1, "R6 zero prescaler, R7 late fix");
    illegalCase(2, 16'h0500, 5, 1'b0, 1'b0, "R6 zero low field");
    illegalCase(2, 5, 16'h0300, 1'b0, 1'b0, "R6 zero high field");
    illegalCase(2, 16'h0005, 16'h0505, 1'b1, 1'b0, "R6 zero second-set field");

    // R9: disable mid-phase then re-enable from scratch
    setCfg(2, 10, 2, 1'b0);
    @(negedge clk);
    enable = 1'b1;
    while (!sclPullLow) @(negedge clk);
    repeat (3) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(!sclPullLow && !clkPhaseHigh && !sampleTick, "R9 released after disable",
          {sclPullLow, clkPhaseHigh, sampleTick}, 0);
    repeat (3) @(negedge clk);
    pushPeriods(1, lowLen(2, 10), relLen(2, 2, 0), "R9 fresh low after re-enable");
    enable = 1'b1;
    waitQueue();
    stopRun();

    // R1: tick position and spacing; R3: phase indicator
    setCfg(3, 10, 2, 1'b0);
    @(negedge clk);
    enable = 1'b1;
    while (!sclPullLow) @(negedge clk);
    begin
      int idx = 0;
      int firstIdx = -1;
      int secondIdx = -1;
      while (secondIdx < 0 && idx < 100) begin
        if (sampleTick) begin
          if (firstIdx < 0) firstIdx = idx;
          else secondIdx = idx;
        end
        if (secondIdx < 0) begin
          @(negedge clk);
          idx++;
        end
      end
      check(firstIdx == 3, "R1 first tick offset", firstIdx, 3);
      check(secondIdx - firstIdx == 4, "R1 tick spacing", secondIdx - firstIdx, 4);
    end
    while (sclPullLow) @(negedge clk);
    check(!clkPhaseHigh, "R3 wait cycle before high count", clkPhaseHigh, 0);
    @(negedge clk);
    check(clkPhaseHigh && !sclPullLow, "R3 high count indicated",
          {clkPhaseHigh, sclPullLow}, 2);
    stopRun();

    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL watchdog expired (all requirements): actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule